// File: doc/BRIEF.md
# MDIO Single-Command Management Master

This block is a register-mapped master for the MDIO management bus. Software writes a command word that holds an opcode, a PHY address and a register address, and sets a go bit in the same word. The block then runs one Clause 22 frame on MDC and MDIO. A second register holds the 16-bit value to send. After a read frame it also holds the value that came back.

Software detects the end of an access by polling the command register until the go bit reads zero. While a frame is in flight, both registers are locked against writes. A command with an opcode that is neither read nor write is recorded, but it never starts the bus. MDC is the system clock divided down by a parameter, and MDC sits low whenever the bus is idle.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, the command and data registers read zero, and mdc and mdio_oe are low.
- R2: The command register sits at address CMD_ADDR and the data register at CMD_ADDR+1. In the command word, bit 20 is the go bit, bits 17:16 are the opcode, bits 12:8 are the PHY address and bits 4:0 are the register address. All other command bits read zero. The data register reads back all 32 written bits. Any other address reads zero.
- R3: Writing the command word with bit 20 set and opcode 01 (write) or 10 (read) starts a frame. Bit 20 reads 1 until the frame ends and then reads 0. The frame lasts 64 MDC periods, which is 128*CLK_DIV clocks from the write edge.
- R4: Writing the command word with bit 20 set and opcode 00 or 11 stores the fields, but bit 20 reads 0 on the next cycle. MDC stays idle and mdio_oe stays low.
- R5: A write frame sends these bits, each MSB first: 32 ones, then 01, then 01, then the PHY address, then the register address, then 10, then data register bits 15:0. mdio_oe is high for all 64 bits.
- R6: A read frame sends the same header with opcode 10. mdio_oe is low for bit positions 46 to 63, which are the turnaround and the 16 data bits.
- R7: During a read frame, mdio_i is sampled at the MDC rising edge of bit positions 48 to 63, MSB first. At the end of the frame the 16 sampled bits go to data register bits 31:16, and bits 15:0 keep their value.
- R8: While bit 20 reads 1, writes to either register are ignored.
- R9: Each MDC period is CLK_DIV clocks low followed by CLK_DIV clocks high. mdio_o and mdio_oe change only while MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when mdio_oe is high |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
The bench builds the block with CLK_DIV set to 3 and CMD_ADDR moved to 0x5C.

- The odd divider makes a swapped low/high half-period or an off-by-one count visible as a wrong MDC period. It also keeps each frame to 384 clocks, so write, read, lock-out and reserved-opcode scenarios all fit in a short run.
- The non-default base address shows that the data register decode follows CMD_ADDR+1 rather than a fixed value.
- A PHY model in the bench returns asymmetric read patterns, so reversed bit order or a missed sample shows up in the upper half of the data register.

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master #(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h40,
  parameter int              CLK_DIV  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(CMD_ADDR + 1);
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [5:0] TA_POS  = 6'd46;
  localparam logic [5:0] DAT_POS = 6'd48;
  localparam logic [5:0] END_POS = 6'd63;

  logic             busy, mdc_q;
  logic [1:0]       op_q;
  logic [4:0]       phy_q, reg_q;
  logic [31:0]      data_q;
  logic [5:0]       bit_idx;
  logic [DIV_W-1:0] div_cnt;
  logic [15:0]      rd_shift;

  wire cmd_wr = reg_we && !busy && (reg_addr == CMD_ADDR);
  wire dat_wr = reg_we && !busy && (reg_addr == DATA_ADDR);
  wire op_ok  = (reg_wdata[17:16] == OP_WR) || (reg_wdata[17:16] == OP_RD);
  wire is_rd  = (op_q == OP_RD);
  wire tick   = (div_cnt == DIV_W'(CLK_DIV - 1));
  wire [63:0] frame = {32'hFFFF_FFFF, 2'b01, op_q, phy_q, reg_q, 2'b10, data_q[15:0]};

  assign mdc     = mdc_q;
  assign mdio_o  = busy & frame[END_POS - bit_idx];
  assign mdio_oe = busy && !(is_rd && bit_idx >= TA_POS);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CMD_ADDR)
      reg_rdata = {11'd0, busy, 2'd0, op_q, 3'd0, phy_q, 3'd0, reg_q};
    else if (reg_addr == DATA_ADDR)
      reg_rdata = data_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mdc_q    <= 1'b0;
      op_q     <= '0;
      phy_q    <= '0;
      reg_q    <= '0;
      data_q   <= '0;
      bit_idx  <= '0;
      div_cnt  <= '0;
      rd_shift <= '0;
    end else begin
      if (cmd_wr) begin
        op_q  <= reg_wdata[17:16];
        phy_q <= reg_wdata[12:8];
        reg_q <= reg_wdata[4:0];
        if (reg_wdata[20] && op_ok) begin
          busy    <= 1'b1;
          bit_idx <= '0;
          div_cnt <= '0;
          mdc_q   <= 1'b0;
        end
      end
      if (dat_wr) data_q <= reg_wdata;
      if (busy) begin
        if (tick) begin
          div_cnt <= '0;
          if (!mdc_q) begin
            mdc_q <= 1'b1;
            if (is_rd && bit_idx >= DAT_POS) rd_shift <= {rd_shift[14:0], mdio_i};
          end else begin
            mdc_q <= 1'b0;
            if (bit_idx == END_POS) begin
              busy <= 1'b0;
              if (is_rd) data_q[31:16] <= rd_shift;
            end else begin
              bit_idx <= bit_idx + 6'd1;
            end
          end
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk #(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [1:0]        op_q,
  input logic [4:0]        phy_q,
  input logic [4:0]        reg_q,
  input logic [31:0]       data_q
);
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  p_reserved_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !busy && reg_addr == CMD_ADDR && reg_wdata[20] &&
     (reg_wdata[17:16] == 2'b00 || reg_wdata[17:16] == 2'b11)) |=> !busy);

  p_start_mdc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mdc);

  p_mdio_stable_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_locked_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(data_q) && $stable({op_q, phy_q, reg_q})));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .op_q(op_q), .phy_q(phy_q), .reg_q(reg_q), .data_q(data_q)
);

// File: tb/tb_mdio_cmd_master.sv
module tb_mdio_cmd_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;
  localparam logic [7:0] CMDA = 8'h5C;
  localparam logic [7:0] DATA = 8'h5D;

  logic clk = 0, rst_n = 0, reg_we = 0, mdio_i = 0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, fails = 0;

  int cap_n = 0;
  logic cap_o [64];
  logic cap_oe [64];
  time rise_t [2];
  time fall_t;
  logic [15:0] resp = '0;

  mdio_cmd_master #(.ADDR_W(8), .CMD_ADDR(CMDA), .CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge mdc) begin
    if (cap_n < 2) rise_t[cap_n] = $time;
    if (cap_n < 64) begin
      cap_o[cap_n] = mdio_o;
      cap_oe[cap_n] = mdio_oe;
    end
    cap_n = cap_n + 1;
  end

  always @(negedge mdc) begin
    if (cap_n == 1) fall_t = $time;
    if (cap_n >= 48 && cap_n <= 63) mdio_i = resp[63 - cap_n];
    else mdio_i = 1'b0;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done(output int n);
    logic [31:0] v;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      rd(CMDA, v);
    end while (v[20] && n < 2000);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(CMDA, v); check("R1 cmd", v, 0);
    rd(DATA, v); check("R1 data", v, 0);
    check("R1 mdc", mdc, 0);
    check("R1 oe", mdio_oe, 0);
  endtask

  task automatic t_readback;
    logic [31:0] v;
    wr(CMDA, 32'hFFFF_FFFF);
    rd(CMDA, v); check("R2 cmd fields, reserved bits zero", v, 32'h0003_1F1F);
    wr(DATA, 32'hDEAD_BEEF);
    rd(DATA, v); check("R2 data readback", v, 32'hDEAD_BEEF);
    rd(8'h5E, v); check("R2 unmapped zero", v, 0);
  endtask

  task automatic t_reserved(input logic [1:0] op);
    logic [31:0] v;
    cap_n = 0;
    wr(CMDA, 32'h0010_0307 | (32'(op) << 16));
    rd(CMDA, v); check("R4 reserved op go clear", v, 32'h0000_0307 | (32'(op) << 16));
    repeat (20) begin
      @(negedge clk);
      if (mdio_oe) check("R4 oe low", 1, 0);
    end
    check("R4 no mdc edges", cap_n, 0);
  endtask

  task automatic t_write_frame(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
    logic [31:0] v;
    logic [63:0] exp, got;
    int n, bad_oe;
    wr(DATA, {16'h7777, wd});
    cap_n = 0;
    wr(CMDA, {11'd0, 1'b1, 2'd0, 2'b01, 3'd0, phy, 3'd0, ra});
    rd(CMDA, v); check("R3 go reads 1 after start", v[20], 1);
    wait_done(n);
    check("R3 frame length clocks", n, 128 * DIV);
    check("R5 bit count", cap_n, 64);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, wd};
    bad_oe = 0;
    for (int i = 0; i < 64; i++) begin
      got[63 - i] = cap_o[i];
      if (!cap_oe[i]) bad_oe++;
    end
    check("R5 write frame bits", got, exp);
    check("R5 oe high all bits", bad_oe, 0);
  endtask

  task automatic t_read_frame(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] r);
    logic [31:0] v;
    logic [45:0] hdr;
    logic [63:0] oe_got;
    int n;
    wr(DATA, 32'h0000_BEEF);
    resp = r;
    cap_n = 0;
    wr(CMDA, {11'd0, 1'b1, 2'd0, 2'b10, 3'd0, phy, 3'd0, ra});
    wait_done(n);
    for (int i = 0; i < 46; i++) hdr[45 - i] = cap_o[i];
    for (int i = 0; i < 64; i++) oe_got[63 - i] = cap_oe[i];
    check("R6 read header", {18'd0, hdr}, {18'd0, 32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra});
    check("R6 oe pattern", oe_got, {{46{1'b1}}, 18'd0});
    rd(DATA, v); check("R7 read result upper, lower kept", v, {r, 16'hBEEF});
    check("R9 mdc period", rise_t[1] - rise_t[0], 2 * DIV * CLK_PERIOD);
    check("R9 mdc high time", fall_t - rise_t[0], DIV * CLK_PERIOD);
  endtask

  task automatic t_busy_lock;
    logic [31:0] v;
    logic [63:0] got;
    int n;
    wr(DATA, 32'h0000_C3A5);
    cap_n = 0;
    wr(CMDA, 32'h0011_0A05);
    repeat (40) @(negedge clk);
    wr(CMDA, 32'h0012_1F1F);
    wr(DATA, 32'hFFFF_0000);
    wait_done(n);
    rd(CMDA, v); check("R8 cmd unchanged", v, 32'h0001_0A05);
    rd(DATA, v); check("R8 data unchanged", v, 32'h0000_C3A5);
    for (int i = 0; i < 64; i++) got[63 - i] = cap_o[i];
    check("R8 frame unchanged", got, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0A, 5'h05, 2'b10, 16'hC3A5});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_reserved(2'b00);
    t_reserved(2'b11);
    t_write_frame(5'h11, 5'h04, 16'h0D01);
    t_write_frame(5'h00, 5'h1F, 16'h8001);
    t_read_frame(5'h09, 5'h11, 16'hA5C3);
    t_read_frame(5'h1E, 5'h02, 16'h8001);
    t_busy_lock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule